// File: doc/BRIEF.md
# Four-Channel Output Compare Unit

This block provides four identical 16-bit output compare channels that watch a free-running counter supplied from outside. Each channel holds a compare value; on the cycle the counter advances to that value, the channel raises its event flag and applies a programmed action to its own output pin: leave it alone, toggle it, drive it low or drive it high. Flags are cleared by writing ones, and an interrupt request line is raised whenever an enabled channel has its flag set.

Software produces jitter-free periodic waveforms by reading a channel's compare value, adding a half-period and writing the sum back after each event; the pin edge then lands on an exact count no matter how late the handler runs. A force register lets software apply a channel's pin action at once, without a match and without touching the flag.

All registers sit on a simple single-cycle write port with a combinational read port, 16 bits wide, addressed by a 3-bit index.

Top module: `ocUnit`

## Requirements
- R1: After reset the four compare registers read 0xFFFF, the control, flag and enable registers read 0, all pins are 0 and the interrupt line is 0.
- R2: When countTick is 1 and count equals a channel's compare value, that channel's flag is set on that clock edge; its flag appears in register 5 at bit 6 minus the channel number (channel 0 at bit 6, channel 3 at bit 3).
- R3: No match occurs when countTick is 0 or when count differs from the compare value; neither flag nor pin changes.
- R4: Register 4 holds a 2-bit action per channel, channel 0 in bits 7:6, channel 1 in 5:4, channel 2 in 3:2, channel 3 in 1:0; code 00 leaves the pin, 01 inverts it, 10 drives it to 0, 11 drives it to 1, applied on the edge of the match.
- R5: Writing 1 to a flag bit in register 5 clears it; writing 0 leaves it unchanged.
- R6: If a match and a clearing write to the same flag occur on the same edge, the flag ends set.
- R7: Register 6 holds interrupt enables at the same bit positions as the flags; irq is 1 exactly when some channel has both its flag and its enable set.
- R8: Writing 1 to a bit of register 7 (same bit positions as the flags) applies that channel's pin action on that edge without setting its flag; register 7 always reads 0.
- R9: Registers 0 to 3 are the 16-bit compare values of channels 0 to 3 and read back what was written; several channels matching the same count all act on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| count | input | 16 | Free-running counter value |
| countTick | input | 1 | High on the cycle the counter holds a new value |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register index |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| pins | output | 4 | Compare output pins, bit n for channel n |
| irq | output | 1 | Combined interrupt request |

## Verification
The in-RTL assertions check on every cycle that a match always leaves its flag set, that a set flag survives any cycle without a clearing write, that no flag rises without a match, and that each pin follows its action code on a match or force and holds otherwise. What only the bench's scenarios show is the register map itself: the bit position of each channel's action, flag, enable and force bit, the reset values, the precedence of a match over a same-edge clear, and that a force leaves the flag alone while several channels firing together all act.

// File: rtl/ocPkg.sv
package ocPkg;
  localparam int NUM_CH   = 4;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int ACT_W    = 2;
  localparam int FLAG_TOP = 6;
  localparam int CTRL_W   = NUM_CH * ACT_W;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_FORCE = 3'd7;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pinAct_t;

  typedef struct packed {
    logic [NUM_CH-1:0] cmpWr;
    logic [NUM_CH-1:0] forceStb;
    logic [CNT_W-1:0]  data;
  } ocStrobes_t;
endpackage

// File: rtl/ocDatapath.sv
module ocDatapath
  import ocPkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [CNT_W-1:0]               count,
  input  logic                           countTick,
  input  ocStrobes_t                     strobes,
  input  logic [NUM_CH-1:0][ACT_W-1:0]   actions,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmpRegs,
  output logic [NUM_CH-1:0]              hit,
  output logic [NUM_CH-1:0]              pins
);
  logic [NUM_CH-1:0] fire;

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    pinAct_t act;
    logic    pinNext;

    assign act     = pinAct_t'(actions[i]);
    assign hit[i]  = countTick && (count == cmpRegs[i]);
    assign fire[i] = hit[i] || strobes.forceStb[i];

    always_comb begin
      pinNext = pins[i];
      if (fire[i]) begin
        case (act)
          ACT_TOGGLE: pinNext = ~pins[i];
          ACT_LOW:    pinNext = 1'b0;
          ACT_HIGH:   pinNext = 1'b1;
          default:    pinNext = pins[i];
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpRegs[i] <= '1;
        pins[i]    <= 1'b0;
      end else begin
        if (strobes.cmpWr[i]) cmpRegs[i] <= strobes.data;
        pins[i] <= pinNext;
      end
    end

    // R4
    toggle_act_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fire[i] && actions[i] == 2'b01) |=> (pins[i] != $past(pins[i])));
    // R4
    drive_act_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fire[i] && actions[i][1]) |=> (pins[i] == $past(actions[i][0])));
    // R3
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!fire[i] || actions[i] == 2'b00) |=> $stable(pins[i]));
  end
endmodule

// File: rtl/ocCtrl.sv
module ocCtrl
  import ocPkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWr,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [CNT_W-1:0]               busWdata,
  output logic [CNT_W-1:0]               busRdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cmpRegs,
  input  logic [NUM_CH-1:0]              hit,
  output ocStrobes_t                     strobes,
  output logic [NUM_CH-1:0][ACT_W-1:0]   actions,
  output logic [NUM_CH-1:0]              flags,
  output logic [NUM_CH-1:0]              enables
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              wrCtrl, wrFlag, wrEn, wrForce;
  logic [NUM_CH-1:0] clrMask, forceMask, flagField, enField;

  assign wrCtrl  = busWr && (busAddr == ADDR_CTRL);
  assign wrFlag  = busWr && (busAddr == ADDR_FLAG);
  assign wrEn    = busWr && (busAddr == ADDR_EN);
  assign wrForce = busWr && (busAddr == ADDR_FORCE);

  for (genvar i = 0; i < NUM_CH; i++) begin : gMap
    assign clrMask[i]   = wrFlag  && busWdata[FLAG_TOP-i];
    assign forceMask[i] = wrForce && busWdata[FLAG_TOP-i];
    assign strobes.cmpWr[i] = busWr && (busAddr == ADDR_W'(i));
    assign actions[i] = ctrlReg[CTRL_W-1-ACT_W*i -: ACT_W];

    always_ff @(posedge clk) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= hit[i] || (flags[i] && !clrMask[i]);
    end

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      hit[i] |=> flags[i]);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !clrMask[i]) |=> flags[i]);
    // R8
    flag_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      !hit[i] |=> !$rose(flags[i]));
  end

  assign strobes.forceStb = forceMask;
  assign strobes.data     = busWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      enables <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= busWdata[CTRL_W-1:0];
      if (wrEn) begin
        for (int i = 0; i < NUM_CH; i++) enables[i] <= busWdata[FLAG_TOP-i];
      end
    end
  end

  always_comb begin
    flagField = '0;
    enField   = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      flagField[NUM_CH-1-i] = flags[i];
      enField[NUM_CH-1-i]   = enables[i];
    end
  end

  localparam int LOW_BIT = FLAG_TOP - NUM_CH + 1;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTRL:  busRdata[CTRL_W-1:0] = ctrlReg;
      ADDR_FLAG:  busRdata[FLAG_TOP:LOW_BIT] = flagField;
      ADDR_EN:    busRdata[FLAG_TOP:LOW_BIT] = enField;
      ADDR_FORCE: busRdata = '0;
      default:    busRdata = cmpRegs[busAddr[1:0]];
    endcase
  end
endmodule

// File: rtl/ocUnit.sv
module ocUnit
  import ocPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  count,
  input  logic              countTick,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] pins,
  output logic              irq
);
  ocStrobes_t                   strobes;
  logic [NUM_CH-1:0][ACT_W-1:0] actions;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpRegs;
  logic [NUM_CH-1:0]            hit, flags, enables;

  ocCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cmpRegs(cmpRegs),
    .hit(hit), .strobes(strobes), .actions(actions),
    .flags(flags), .enables(enables)
  );

  ocDatapath uDp (
    .clk(clk), .rstN(rstN), .count(count), .countTick(countTick),
    .strobes(strobes), .actions(actions), .cmpRegs(cmpRegs),
    .hit(hit), .pins(pins)
  );

  assign irq = |(flags & enables);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit != '0 && (hit & enables) == hit && enables != '0) |=> irq);
endmodule

// File: tb/ocUnit_test.sv
module ocUnit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] count = '0;
  logic        countTick = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [3:0]  pins;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocUnit uut (
    .clk(clk), .rstN(rstN), .count(count), .countTick(countTick),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pins(pins), .irq(irq)
  );

  // act, cmp, count, tick, expected pin0, expected flag0
  localparam logic [36:0] VEC [8] = '{
    {2'b11, 16'h0100, 16'h0100, 1'b1, 1'b1, 1'b1},
    {2'b01, 16'h0200, 16'h0200, 1'b1, 1'b0, 1'b1},
    {2'b01, 16'h0300, 16'h0300, 1'b0, 1'b0, 1'b0},
    {2'b01, 16'h0300, 16'h0301, 1'b1, 1'b0, 1'b0},
    {2'b01, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1},
    {2'b10, 16'h1234, 16'h1234, 1'b1, 1'b0, 1'b1},
    {2'b00, 16'h0042, 16'h0042, 1'b1, 1'b0, 1'b1},
    {2'b11, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [15:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(logic [2:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic applyCount(logic [15:0] c, logic t);
    count = c; countTick = t;
    @(negedge clk);
    countTick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      readReg(3'(a), rd); check("R1 compare reset", rd, 16'hFFFF);
    end
    for (int a = 4; a < 8; a++) begin
      readReg(3'(a), rd); check("R1 register reset", rd, 16'h0000);
    end
    check("R1 pins reset", {12'h0, pins}, 16'h0);
    check("R1 irq reset", {15'h0, irq}, 16'h0);

    // R2 R3 R4 table walk on channel 0
    for (int v = 0; v < 8; v++) begin
      logic [36:0] e;
      e = VEC[v];
      busWrite(3'd5, 16'h0078);
      busWrite(3'd4, {8'h00, e[36:35], 6'b0});
      busWrite(3'd0, e[34:19]);
      applyCount(e[18:3], e[2]);
      check("R4 table pin", {15'h0, pins[0]}, {15'h0, e[1]});
      readReg(3'd5, rd);
      check("R2 R3 table flag", {15'h0, rd[6]}, {15'h0, e[0]});
    end

    // R7 irq from channel 1, R5 write-zero keeps flag
    busWrite(3'd5, 16'h0078);
    busWrite(3'd4, 16'h0000);
    busWrite(3'd6, 16'h0020);
    busWrite(3'd1, 16'h0500);
    check("R7 irq idle", {15'h0, irq}, 16'h0);
    applyCount(16'h0500, 1'b1);
    check("R7 irq asserted", {15'h0, irq}, 16'h1);
    busWrite(3'd5, 16'h0000);
    readReg(3'd5, rd);
    check("R5 write zero keeps flag", rd, 16'h0020);
    busWrite(3'd5, 16'h0020);
    readReg(3'd5, rd);
    check("R5 write one clears", rd, 16'h0000);
    check("R7 irq cleared", {15'h0, irq}, 16'h0);
    busWrite(3'd6, 16'h0040);
    applyCount(16'h0500, 1'b1);
    check("R7 masked flag no irq", {15'h0, irq}, 16'h0);
    readReg(3'd6, rd);
    check("R7 enable readback", rd, 16'h0040);

    // R6 match beats same-edge clear
    busWrite(3'd5, 16'h0078);
    busWrite(3'd0, 16'h0600);
    busWr = 1'b1; busAddr = 3'd5; busWdata = 16'h0040;
    count = 16'h0600; countTick = 1'b1;
    @(negedge clk);
    busWr = 1'b0; countTick = 1'b0;
    readReg(3'd5, rd);
    check("R6 set wins", rd, 16'h0040);
    check("R6 irq follows", {15'h0, irq}, 16'h1);

    // R8 force on channel 2
    busWrite(3'd5, 16'h0078);
    busWrite(3'd4, 16'h000C);
    busWrite(3'd7, 16'h0010);
    check("R8 force drives high", {15'h0, pins[2]}, 16'h1);
    readReg(3'd5, rd);
    check("R8 force leaves flag", rd, 16'h0000);
    readReg(3'd7, rd);
    check("R8 force reads zero", rd, 16'h0000);
    busWrite(3'd4, 16'h0004);
    busWrite(3'd7, 16'h0010);
    check("R8 force toggles", {15'h0, pins[2]}, 16'h0);

    // R9 simultaneous channels and compare readback
    busWrite(3'd4, 16'h000D);
    busWrite(3'd2, 16'h0700);
    busWrite(3'd3, 16'h0700);
    applyCount(16'h0700, 1'b1);
    check("R9 both pins act", {12'h0, pins[3:2]}, 16'h0003);
    readReg(3'd5, rd);
    check("R9 both flags", rd, 16'h0018);
    busWrite(3'd3, 16'hBEEF);
    readReg(3'd3, rd);
    check("R9 compare readback", rd, 16'hBEEF);
    readReg(3'd4, rd);
    check("R4 control readback", rd, 16'h000D);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule